// File: doc/BRIEF.md
# Frame Speech/Silence Decider with Adaptive Energy Gate

This block makes one speech-or-silence decision per audio frame. It receives a strobe with the frame's mean energy and its zero-crossing count. One clock later it returns a single-bit verdict. The primary test compares the energy against an adaptive gate. A frame that fails that test can still be declared speech in two ways. The first is a short hangover that follows recent genuine speech. The second is a zero-crossing window that catches weak unvoiced sounds.

The gate follows the signal level. A run of three equal verdicts moves it one 3 dB step. The energy is linear, so a 3 dB step is a doubling or a halving. A guard margin of 12 dB (a factor of 16) relative to the current frame energy can veto the step. The result is always held between two fixed limits. The gate is also driven out as a port, so that downstream logic can see the level the next frame will be compared against.

Top module: `vad_frame_decide`

## Requirements
- R1: After reset, `vad_valid` and `vad_speech` are 0, `vad_gate` equals GATE_INIT (default 4096), the hangover history is empty and the run counter is cleared, with the previous verdict taken as silence.
- R2: A frame whose energy is strictly greater than the current gate is speech. Energy equal to the gate does not count as speech by energy.
- R3: A frame that fails R2 is speech when at least one of the three preceding frames was a primary speech frame. A primary speech frame is one made speech by R2 or R5.
- R4: A frame made speech only by the hangover of R3 is not a primary frame and does not extend the hangover. After one isolated primary frame followed by quiet frames outside the zero-crossing window, exactly three frames are speech, and the fourth is silence.
- R5: A frame that fails R2 and R3 is speech when its zero-crossing count lies in 30..70, both ends included. Otherwise it is silence.
- R6: The verdict appears on `vad_speech` with `vad_valid` high exactly one cycle after `frame_valid`. Without `frame_valid`, `vad_valid` is 0 and `vad_speech`, `vad_gate` and all history hold their values.
- R7: When a speech verdict completes a run of three equal verdicts, the gate doubles. The step is skipped when twice the gate exceeds the frame energy shifted right by 4. A doubled value above GATE_MAX (default 262144) becomes GATE_MAX.
- R8: When a silence verdict completes a run of three equal verdicts, the gate halves, rounding down. The step is skipped when the halved value is below 16 times the frame energy. A halved value below GATE_MIN (default 100) becomes GATE_MIN.
- R9: A run counts consecutive equal verdicts. It restarts at one when the verdict differs from the previous frame's verdict, and it restarts at zero after every third frame, whether the gate step was applied or vetoed. The new gate takes effect from the next frame onward.
- R10: `vad_gate` always lies within GATE_MIN..GATE_MAX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_valid | input | 1 | One-cycle strobe: frame statistics present |
| frame_energy | input | EW (24) | Linear mean energy of the frame |
| frame_zc | input | ZW (7) | Zero-crossing count of the frame |
| vad_valid | output | 1 | Verdict strobe, one cycle after `frame_valid` |
| vad_speech | output | 1 | 1 = speech, 0 = silence; held between frames |
| vad_gate | output | EW (24) | Current energy gate |

## Verification
The bench probes energy exactly equal to the gate. A design using `>=` would wrongly report speech on that frame. It walks the zero-crossing count over 29, 30, 70 and 71, where an off-by-one window flips one of those verdicts. After one isolated primary frame, it expects exactly three hangover frames. A design that let smoothed frames refresh the history would keep speech alive indefinitely. Gate runs are driven into both clamps and into both 12 dB vetoes. A design that failed to reset the run counter after a vetoed step, or that clamped wrongly, would leave `vad_gate` off the value computed by the reference model, and this shows up across several thousand random frames.

// File: rtl/vad_decide_pkg.sv
package vad_decide_pkg;

    // Which rule produced the verdict of a frame
    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_ENERGY = 2'd1,
        SRC_HANG   = 2'd2,
        SRC_ZC     = 2'd3
    } vad_src_e;

    typedef struct packed {
        logic valid;
        logic speech;
    } vad_out_t;

endpackage

// File: rtl/vad_hangover.sv
module vad_hangover #(
    parameter int HANG = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_valid,
    input  logic primary_speech,
    output logic hang_active
);
    typedef struct packed {
        logic [HANG-1:0] attr;
    } hang_st_t;

    hang_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (frame_valid) begin
            st_d.attr = {st_q.attr[HANG-2:0], primary_speech};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hang_active = |st_q.attr;

    // R4: only primary frames enter the history
    a_r4_history_entry: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> (st_q.attr[0] == $past(primary_speech)));

    // R6: history holds when no frame arrives
    a_r6_history_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid |=> $stable(st_q.attr));

endmodule

// File: rtl/vad_gate_adapt.sv
module vad_gate_adapt #(
    parameter int EW        = 24,
    parameter int RUN_LEN   = 3,
    parameter int GATE_MIN  = 100,
    parameter int GATE_MAX  = 262144,
    parameter int GATE_INIT = 4096
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_valid,
    input  logic          verdict,
    input  logic [EW-1:0] energy,
    output logic [EW-1:0] gate
);
    localparam int RW = $clog2(RUN_LEN + 1);
    localparam logic [EW:0]   MAX_W  = (EW+1)'(GATE_MAX);
    localparam logic [EW-1:0] MIN_V  = EW'(GATE_MIN);
    localparam logic [EW-1:0] INIT_V = EW'(GATE_INIT);
    localparam logic [RW-1:0] RUN_V  = RW'(RUN_LEN);

    typedef struct packed {
        logic [EW-1:0] gate;
        logic [RW-1:0] run;
        logic          last;
    } gate_st_t;

    gate_st_t st_d, st_q;

    logic [RW-1:0] run_next;
    logic [EW:0]   dbl;
    logic [EW:0]   ceil_e;
    logic [EW-1:0] half;
    logic [EW+3:0] floor_e;

    always_comb begin
        st_d     = st_q;
        run_next = (verdict == st_q.last) ? st_q.run + 1'b1 : RW'(1);
        dbl      = {st_q.gate, 1'b0};
        ceil_e   = {5'b0, energy[EW-1:4]};
        half     = st_q.gate >> 1;
        floor_e  = {energy, 4'b0};
        if (frame_valid) begin
            st_d.last = verdict;
            st_d.run  = run_next;
            if (run_next == RUN_V) begin
                st_d.run = '0;
                if (verdict) begin
                    if (dbl <= ceil_e) begin
                        st_d.gate = (dbl > MAX_W) ? MAX_W[EW-1:0] : dbl[EW-1:0];
                    end
                end else begin
                    if ({4'b0, half} >= floor_e) begin
                        st_d.gate = (half < MIN_V) ? MIN_V : half;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.gate <= INIT_V;
            st_q.run  <= '0;
            st_q.last <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gate = st_q.gate;

    // R10: gate stays inside its limits
    a_r10_gate_range: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.gate >= MIN_V) && ({1'b0, st_q.gate} <= MAX_W));

    // R6: gate only moves on a frame
    a_r6_gate_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid |=> $stable(st_q.gate));

    // R9: run counter never reaches the run length in state
    a_r9_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run < RUN_V);

    // R7/R8: any move is a doubling or a halving, clamped
    a_r7_r8_step_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.gate != $past(st_q.gate)) |->
            (({1'b0, st_q.gate} == (({$past(st_q.gate), 1'b0} > MAX_W) ? MAX_W : {$past(st_q.gate), 1'b0}))
          || (st_q.gate == ((($past(st_q.gate) >> 1) < MIN_V) ? MIN_V : ($past(st_q.gate) >> 1)))));

endmodule

// File: rtl/vad_frame_decide.sv
module vad_frame_decide
    import vad_decide_pkg::*;
#(
    parameter int EW        = 24,
    parameter int ZW        = 7,
    parameter int HANG      = 3,
    parameter int RUN_LEN   = 3,
    parameter int ZC_LO     = 30,
    parameter int ZC_HI     = 70,
    parameter int GATE_MIN  = 100,
    parameter int GATE_MAX  = 262144,
    parameter int GATE_INIT = 4096
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_valid,
    input  logic [EW-1:0] frame_energy,
    input  logic [ZW-1:0] frame_zc,
    output logic          vad_valid,
    output logic          vad_speech,
    output logic [EW-1:0] vad_gate
);
    localparam logic [ZW-1:0] ZC_LO_V = ZW'(ZC_LO);
    localparam logic [ZW-1:0] ZC_HI_V = ZW'(ZC_HI);

    vad_src_e      src;
    logic          energy_hit;
    logic          zc_hit;
    logic          hang_active;
    logic          primary;
    logic          verdict;
    logic [EW-1:0] gate;
    vad_out_t      out_d, out_q;

    always_comb begin
        energy_hit = frame_energy > gate;
        zc_hit     = (frame_zc >= ZC_LO_V) && (frame_zc <= ZC_HI_V);
        if (energy_hit)       src = SRC_ENERGY;
        else if (hang_active) src = SRC_HANG;
        else if (zc_hit)      src = SRC_ZC;
        else                  src = SRC_NONE;
        verdict = (src != SRC_NONE);
        primary = (src == SRC_ENERGY) || (src == SRC_ZC);

        out_d       = out_q;
        out_d.valid = frame_valid;
        if (frame_valid) out_d.speech = verdict;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    vad_hangover #(
        .HANG (HANG)
    ) u_hang (
        .clk            (clk),
        .rst_n          (rst_n),
        .frame_valid    (frame_valid),
        .primary_speech (primary),
        .hang_active    (hang_active)
    );

    vad_gate_adapt #(
        .EW        (EW),
        .RUN_LEN   (RUN_LEN),
        .GATE_MIN  (GATE_MIN),
        .GATE_MAX  (GATE_MAX),
        .GATE_INIT (GATE_INIT)
    ) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_valid (frame_valid),
        .verdict     (verdict),
        .energy      (frame_energy),
        .gate        (gate)
    );

    assign vad_valid  = out_q.valid;
    assign vad_speech = out_q.speech;
    assign vad_gate   = gate;

    // R6: verdict strobe follows the frame strobe by one cycle
    a_r6_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> vad_valid);
    a_r6_valid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid |=> (!vad_valid && $stable(vad_speech)));

    // R2: energy above the gate always yields speech
    a_r2_energy_speech: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && (frame_energy > vad_gate)) |=> vad_speech);

    // R5: in-window zero crossings never give silence
    a_r5_zc_window: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && (frame_zc >= ZC_LO_V) && (frame_zc <= ZC_HI_V)) |=> vad_speech);

endmodule

// File: tb/test_vad_frame_decide.sv
module test_vad_frame_decide;
    localparam int CLK_PERIOD = 10;
    localparam int EW = 24;
    localparam int ZW = 7;
    localparam longint GMIN  = 100;
    localparam longint GMAX  = 262144;
    localparam longint GINIT = 4096;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_valid = 1'b0;
    logic [EW-1:0] frame_energy = '0;
    logic [ZW-1:0] frame_zc = '0;
    logic          vad_valid;
    logic          vad_speech;
    logic [EW-1:0] vad_gate;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference state
    longint m_gate;
    bit [2:0] m_hist;
    int m_run;
    bit m_last;
    bit m_speech;

    always #(CLK_PERIOD/2) clk = ~clk;

    vad_frame_decide i_vad_frame_decide (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_valid  (frame_valid),
        .frame_energy (frame_energy),
        .frame_zc     (frame_zc),
        .vad_valid    (vad_valid),
        .vad_speech   (vad_speech),
        .vad_gate     (vad_gate)
    );

    task automatic check(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // R2/R3/R5 verdict, R7/R8/R9 gate update
    function automatic bit model_step(longint e, int z);
        bit by_e, prim, v;
        int rn;
        longint d, h;
        by_e = e > m_gate;
        prim = by_e || (!(|m_hist) && z >= 30 && z <= 70);
        v    = by_e || (|m_hist) || prim;
        m_hist = {m_hist[1:0], prim};
        rn = (v == m_last) ? m_run + 1 : 1;
        m_last = v;
        if (rn == 3) begin
            rn = 0;
            if (v) begin
                d = m_gate * 2;
                if (d <= (e >> 4)) m_gate = (d > GMAX) ? GMAX : d;
            end else begin
                h = m_gate >> 1;
                if (h >= e * 16) m_gate = (h < GMIN) ? GMIN : h;
            end
        end
        m_run = rn;
        return v;
    endfunction

    // called at a negedge; returns at the next negedge
    task automatic send(longint e, int z, string tag);
        frame_valid  = 1'b1;
        frame_energy = EW'(e);
        frame_zc     = ZW'(z);
        m_speech = model_step(e, z);
        @(negedge clk);
        frame_valid = 1'b0;
        check({tag, " R6 valid"}, vad_valid, 1);
        check({tag, " speech"}, vad_speech, m_speech);
        check({tag, " R10 gate"}, vad_gate, m_gate);
    endtask

    task automatic idle_check();
        @(negedge clk);
        check("R6 idle valid", vad_valid, 0);
        check("R6 idle speech held", vad_speech, m_speech);
        check("R6 idle gate held", vad_gate, m_gate);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R6 watchdog expired actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        longint e;
        int z;
        void'($urandom(32'd20250611));
        m_gate = GINIT; m_hist = '0; m_run = 0; m_last = 0; m_speech = 0;
        repeat (3) @(negedge clk);
        check("R1 reset valid", vad_valid, 0);
        check("R1 reset speech", vad_speech, 0);
        check("R1 reset gate", vad_gate, GINIT);
        rst_n = 1'b1;
        @(negedge clk);

        send(GINIT, 0, "R2 equal energy");
        send(0, 29, "R5 zc 29");
        send(0, 71, "R5 zc 71 + R8 first fall");
        send(0, 30, "R5 zc 30");
        send(0, 0, "R3 hang 1");
        send(0, 0, "R3 hang 2");
        send(0, 0, "R3 hang 3");
        send(0, 0, "R4 hang ends");
        check("R4 silence after hangover", vad_speech, 0);
        send(0, 70, "R5 zc 70");
        idle_check();
        for (int i = 0; i < 30; i++) send(0, 0, "R8 fall to min");
        check("R8 clamp at GATE_MIN", vad_gate, GMIN);
        for (int i = 0; i < 40; i++) send(24'hFFFFFF, 0, "R7 rise to max");
        check("R7 clamp at GATE_MAX", vad_gate, GMAX);
        for (int i = 0; i < 9; i++) send(10000, 0, "R8 fall veto");
        check("R8 veto keeps gate", vad_gate, GMAX);
        for (int i = 0; i < 6; i++) send(m_gate + 1, 0, "R7 rise veto");
        check("R7 veto keeps gate", vad_gate, GMAX);
        for (int i = 0; i < 6; i++) send(0, 0, "R9 run restart");
        idle_check();

        for (int i = 0; i < 4000; i++) begin
            case ($urandom % 5)
                0: e = $urandom % (m_gate / 32 + 1);
                1: e = m_gate + 1 + ($urandom % (m_gate * 64));
                2: e = m_gate;
                3: e = $urandom % (m_gate + 1);
                default: e = $urandom % 24'hFFFFFF;
            endcase
            if (e > 24'hFFFFFF) e = 24'hFFFFFF;
            z = (($urandom % 3) == 0) ? ($urandom % 128) : (($urandom % 2) ? 0 : 100);
            send(e, z, "R3 R7 R8 R9 random");
            if (($urandom % 8) == 0) idle_check();
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule